// File: doc/BRIEF.md
# Priority-Level Interrupt Gate

This block holds the interrupt-control part of a 16-bit processor status and control word and decides which pending requests are forwarded to the CPU core as one registered interrupt. It keeps three things: a global enable that is set out of reset, an enable for the stack-overflow request, and a 4-bit level field.

The level field serves one of two purposes, chosen by a mode input. In per-line mask mode, each of its four bits opens one of device lines 1 to 4. In threshold mode, the field is read as a number from 0 to 15. A device line numbered n may pass when n is less than or equal to that number, and the same number is driven out so that external devices can compare it with their own priority. Number 1 is the most urgent.

A request counts only when it is seen high at two consecutive rising edges. The request to the core and the number of the winning source are registered together on the same edge. The reset input is expected to be deasserted synchronously to the clock.

Top module: `irq_level_gate`

## Requirements
- R1: While `rst_n` is low and after its release, `cpu_irq` is 0, `irq_src` is 0 and `level_out` is 0. The global enable resets to 1 and the overflow enable resets to 0.
- R2: A rising edge with `cfg_we` high loads word bit 9 into the global enable, bit 1 into the overflow enable, and bits 5..2 into the level field (bit 2 is the LSB). All other word bits are ignored. `level_out` shows the level field from the next cycle on.
- R3: While the global enable is 0, no source raises `cpu_irq`.
- R4: When the global enable and the overflow enable are both 1, a qualified `ovf_req` raises `cpu_irq` with `irq_src` = 0 and beats every device request. With the overflow enable at 0 it is blocked.
- R5: With `mode_level` = 0, device n (bit n-1 of `dev_req`) is eligible only for n in 1..4, and only while level bit n-1 is 1. Devices 5..15 never pass.
- R6: With `mode_level` = 1, device n is eligible when n <= level. A level of 0 blocks every device.
- R7: When several eligible device requests are qualified at once, `irq_src` reports the lowest number among them.
- R8: A request is qualified only if it is high at two consecutive rising edges. The second of those edges updates `cpu_irq` and `irq_src` together, and `irq_src` is 0 whenever `cpu_irq` is 0.
- R9: The overflow path follows R4 in both modes, whatever the level field holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the status and control word |
| cfg_wdata | input | 16 | Status and control word being written |
| mode_level | input | 1 | 1 = threshold mode, 0 = per-line mask mode |
| ovf_req | input | 1 | Stack-overflow request |
| dev_req | input | 15 | Device requests, bit n-1 is device n |
| level_out | output | 4 | Current level field |
| cpu_irq | output | 1 | Registered interrupt request to the core |
| irq_src | output | 4 | Winning source: 0 = stack overflow, 1..15 = device |

## Verification
Threshold mode is driven with single devices just below, at and just above the level, and with levels 0 and 15. This separates a correct less-or-equal compare from an off-by-one or an inverted compare. Mask mode uses a sparse bit pattern, so that a wrong bit-to-line mapping or leakage into lines 5..15 shows up. Mixed requests, with and without the overflow line, show whether the arbitration order is right. Single-cycle pulses and toggling lines separate the two-edge qualification from plain sampling.

// File: rtl/igate_pkg.sv
package igate_pkg;
  localparam int unsigned WORD_W     = 16;
  localparam int unsigned LVL_W      = 4;
  localparam int unsigned GIE_POS    = 9;
  localparam int unsigned OVF_EN_POS = 1;
  localparam int unsigned LVL_LSB    = 2;

  typedef struct packed {
    logic             gie;
    logic             ovf_en;
    logic [LVL_W-1:0] lvl;
  } igate_cfg_t;
endpackage

// File: rtl/igate_cfg_reg.sv
module igate_cfg_reg
  import igate_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [WORD_W-1:0] wdata,
  output igate_cfg_t        cfg_q
);
  igate_cfg_t cfg_d;
  logic       unused_wbits;

  assign unused_wbits = ^{wdata[WORD_W-1:GIE_POS+1], wdata[GIE_POS-1:LVL_LSB+LVL_W], wdata[0]};

  always_comb begin
    cfg_d = cfg_q;
    if (we) begin
      cfg_d.gie    = wdata[GIE_POS];
      cfg_d.ovf_en = wdata[OVF_EN_POS];
      cfg_d.lvl    = wdata[LVL_LSB +: LVL_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q.gie    <= 1'b1;
      cfg_q.ovf_en <= 1'b0;
      cfg_q.lvl    <= '0;
    end else if (we) begin
      cfg_q <= cfg_d;
    end
  end
endmodule

// File: rtl/igate_stable.sv
module igate_stable #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw,
  output logic [W-1:0] stable
);
  logic [W-1:0] seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_q <= '0;
    else        seen_q <= raw;
  end

  assign stable = seen_q & raw;
endmodule

// File: rtl/igate_elig.sv
module igate_elig
  import igate_pkg::*;
#(
  parameter int unsigned NUM_DEV = 15
) (
  input  igate_cfg_t         cfg,
  input  logic               mode_level,
  input  logic [NUM_DEV-1:0] dev_stb,
  output logic [NUM_DEV-1:0] dev_ok
);
  for (genvar i = 0; i < NUM_DEV; i++) begin : g_line
    localparam int unsigned PRIO = i + 1;
    logic thr_ok;
    logic msk_ok;
    assign thr_ok = (32'(cfg.lvl) >= PRIO);
    if (i < LVL_W) begin : g_mask
      assign msk_ok = cfg.lvl[i];
    end else begin : g_nomask
      assign msk_ok = 1'b0;
    end
    assign dev_ok[i] = cfg.gie & dev_stb[i] & (mode_level ? thr_ok : msk_ok);
  end
endmodule

// File: rtl/igate_arb.sv
module igate_arb #(
  parameter int unsigned NUM_DEV = 15,
  parameter int unsigned SRC_W   = 4
) (
  input  logic               ovf_ok,
  input  logic [NUM_DEV-1:0] dev_ok,
  output logic               any,
  output logic [SRC_W-1:0]   src
);
  always_comb begin
    any = ovf_ok | (|dev_ok);
    src = '0;
    if (!ovf_ok) begin
      for (int i = NUM_DEV - 1; i >= 0; i--) begin
        if (dev_ok[i]) src = SRC_W'(i + 1);
      end
    end
  end
endmodule

// File: rtl/irq_level_gate.sv
module irq_level_gate
  import igate_pkg::*;
#(
  parameter int unsigned NUM_DEV = 15,
  localparam int unsigned SRC_W  = $clog2(NUM_DEV + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [15:0]        cfg_wdata,
  input  logic               mode_level,
  input  logic               ovf_req,
  input  logic [NUM_DEV-1:0] dev_req,
  output logic [LVL_W-1:0]   level_out,
  output logic               cpu_irq,
  output logic [SRC_W-1:0]   irq_src
);
  localparam int unsigned REQ_W = NUM_DEV + 1;

  igate_cfg_t         cfg_q;
  logic [REQ_W-1:0]   req_stb;
  logic [NUM_DEV-1:0] dev_ok;
  logic               ovf_ok;
  logic               win_any;
  logic [SRC_W-1:0]   win_src;
  logic               irq_d;
  logic [SRC_W-1:0]   src_d;

  igate_cfg_reg u_cfg (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (cfg_we),
    .wdata (cfg_wdata),
    .cfg_q (cfg_q)
  );

  igate_stable #(.W(REQ_W)) u_stb (
    .clk    (clk),
    .rst_n  (rst_n),
    .raw    ({dev_req, ovf_req}),
    .stable (req_stb)
  );

  igate_elig #(.NUM_DEV(NUM_DEV)) u_elig (
    .cfg        (cfg_q),
    .mode_level (mode_level),
    .dev_stb    (req_stb[REQ_W-1:1]),
    .dev_ok     (dev_ok)
  );

  assign ovf_ok = cfg_q.gie & cfg_q.ovf_en & req_stb[0];

  igate_arb #(.NUM_DEV(NUM_DEV), .SRC_W(SRC_W)) u_arb (
    .ovf_ok (ovf_ok),
    .dev_ok (dev_ok),
    .any    (win_any),
    .src    (win_src)
  );

  always_comb begin
    irq_d = win_any;
    src_d = win_any ? win_src : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpu_irq <= 1'b0;
      irq_src <= '0;
    end else begin
      cpu_irq <= irq_d;
      irq_src <= src_d;
    end
  end

  assign level_out = cfg_q.lvl;

  // R3
  gie_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_irq |-> $past(cfg_q.gie));

  // R8
  src_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_irq |-> (irq_src == '0));

  // R4
  ovf_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_irq && irq_src == '0) |-> ($past(cfg_q.ovf_en) && $past(ovf_req)));

  // R6
  lvl_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_irq && irq_src != '0 && $past(mode_level)) |-> (32'(irq_src) <= 32'($past(cfg_q.lvl))));

  // R5
  mask_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_irq && irq_src != '0 && !$past(mode_level)) |-> (32'(irq_src) <= LVL_W));
endmodule

// File: tb/irq_level_gate_tb.sv
module irq_level_gate_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic        mode_level = 1'b0;
  logic        ovf_req = 1'b0;
  logic [14:0] dev_req = '0;
  logic [3:0]  level_out;
  logic        cpu_irq;
  logic [3:0]  irq_src;

  irq_level_gate u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .mode_level(mode_level), .ovf_req(ovf_req), .dev_req(dev_req),
    .level_out(level_out), .cpu_irq(cpu_irq), .irq_src(irq_src)
  );

  always #5 clk = ~clk;

  int n_run = 0;
  int n_fail = 0;
  int cyc = 0;
  string phase = "R1";
  bit done = 0;

  // behavioural reference model
  bit       m_gie, m_ovf_en;
  bit [3:0] m_lvl;
  bit       p_ovf;
  bit [14:0] p_dev;
  bit       e_irq;
  int       e_src;

  function automatic bit allowed(int n, bit lvl_mode, bit [3:0] lvl);
    if (lvl_mode) return n <= int'(lvl);
    if (n > 4) return 0;
    return lvl[n-1];
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_gie = 1; m_ovf_en = 0; m_lvl = 0; p_ovf = 0; p_dev = 0;
      e_irq = 0; e_src = 0;
    end else begin
      e_irq = 0; e_src = 0;
      if (m_gie) begin
        if (m_ovf_en && p_ovf && ovf_req) begin
          e_irq = 1; e_src = 0;
        end else begin
          for (int n = 1; n <= 15; n++) begin
            if (!e_irq && p_dev[n-1] && dev_req[n-1] && allowed(n, mode_level, m_lvl)) begin
              e_irq = 1; e_src = n;
            end
          end
        end
      end
      if (cfg_we) begin
        m_gie = cfg_wdata[9]; m_ovf_en = cfg_wdata[1]; m_lvl = cfg_wdata[5:2];
      end
      p_ovf = ovf_req; p_dev = dev_req;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      n_run++;
      if (cpu_irq !== e_irq || int'(irq_src) != e_src || level_out !== m_lvl) begin
        n_fail++;
        $display("FAIL %s cycle %0d: irq/src/lvl actual %0b/%0d/%0d expected %0b/%0d/%0d",
                 phase, cyc, cpu_irq, irq_src, level_out, e_irq, e_src, m_lvl);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      done = 1;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected below 20000", cyc);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  task automatic chk(string tag, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] word(bit gie, bit oe, bit [3:0] lvl);
    return (16'(gie) << 9) | (16'(oe) << 1) | (16'(lvl) << 2);
  endfunction

  task automatic wr(logic [15:0] w);
    @(negedge clk);
    cfg_we = 1; cfg_wdata = w;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic hold(bit md, bit ov, logic [14:0] dv, int n);
    @(negedge clk);
    mode_level = md; ovf_req = ov; dev_req = dv;
    repeat (n) @(negedge clk);
  endtask

  task automatic idle();
    hold(mode_level, 0, '0, 2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    phase = "R1";
    chk("R1 reset irq", cpu_irq, 0);
    chk("R1 reset src", irq_src, 0);
    chk("R1 reset level", level_out, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 after release level", level_out, 0);
    chk("R1 after release irq", cpu_irq, 0);

    phase = "R4";
    hold(1, 1, '0, 3);
    chk("R4 overflow blocked by ovf enable 0", cpu_irq, 0);
    idle();
    wr(word(1, 1, 4'd15));
    hold(1, 1, 15'h0001, 3);
    chk("R4 overflow beats device 1", cpu_irq, 1);
    chk("R4 overflow source 0", irq_src, 0);
    idle();

    phase = "R9";
    wr(word(1, 1, 4'd0));
    hold(0, 1, '0, 3);
    chk("R9 overflow in mask mode with level 0", cpu_irq, 1);
    idle();

    phase = "R2";
    wr(word(1, 0, 4'd5));
    chk("R2 level after write", level_out, 5);
    wr(16'hFFCF);
    chk("R2 other word bits ignored", level_out, 3);
    wr(word(1, 0, 4'd5));

    phase = "R6";
    hold(1, 0, 15'h0040, 3);
    chk("R6 device 7 above level 5", cpu_irq, 0);
    hold(1, 0, 15'h0010, 3);
    chk("R6 device 5 at level 5", irq_src, 5);
    hold(1, 0, 15'h0020, 3);
    chk("R6 device 6 above level 5", cpu_irq, 0);
    hold(1, 0, 15'h0008, 3);
    chk("R6 device 4 below level 5", irq_src, 4);
    idle();
    wr(word(1, 0, 4'd0));
    hold(1, 0, 15'h0001, 3);
    chk("R6 level 0 blocks device 1", cpu_irq, 0);
    idle();
    wr(word(1, 0, 4'd15));
    hold(1, 0, 15'h4000, 3);
    chk("R6 device 15 at level 15", irq_src, 15);

    phase = "R7";
    hold(1, 0, 15'h010C, 3);
    chk("R7 lowest of 3,4,9", irq_src, 3);
    hold(1, 0, 15'h0108, 3);
    chk("R7 lowest of 4,9", irq_src, 4);
    idle();

    phase = "R5";
    wr(word(1, 0, 4'b1010));
    hold(0, 0, 15'h0001, 3);
    chk("R5 device 1 masked", cpu_irq, 0);
    hold(0, 0, 15'h0002, 3);
    chk("R5 device 2 open", irq_src, 2);
    hold(0, 0, 15'h000D, 3);
    chk("R5 devices 1,3 masked, 4 open", irq_src, 4);
    idle();
    wr(word(1, 0, 4'b1111));
    hold(0, 0, 15'h7FF0, 3);
    chk("R5 devices 5..15 never pass", cpu_irq, 0);
    idle();

    phase = "R8";
    wr(word(1, 1, 4'd15));
    @(negedge clk);
    mode_level = 1; dev_req = 15'h0004;
    @(negedge clk);
    chk("R8 no irq after first edge", cpu_irq, 0);
    @(negedge clk);
    chk("R8 irq after second edge", cpu_irq, 1);
    chk("R8 source with irq", irq_src, 3);
    dev_req = 0;
    @(negedge clk);
    dev_req = 15'h0002;
    @(negedge clk);
    dev_req = 0;
    @(negedge clk);
    dev_req = 15'h0002;
    @(negedge clk);
    chk("R8 single-cycle pulses ignored", cpu_irq, 0);
    dev_req = 0; ovf_req = 1;
    @(negedge clk);
    ovf_req = 0;
    @(negedge clk);
    chk("R8 overflow pulse ignored", cpu_irq, 0);
    idle();

    phase = "R3";
    wr(word(0, 1, 4'd15));
    hold(1, 1, 15'h7FFF, 3);
    chk("R3 global enable 0 blocks all", cpu_irq, 0);
    chk("R3 source idle", irq_src, 0);
    idle();
    wr(word(1, 1, 4'd15));
    hold(1, 0, 15'h0100, 3);
    chk("R3 global enable restored", irq_src, 9);
    idle();

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule